// File: doc/BRIEF.md
# Dual-Exponent Bit-Pair Exponentiation Sequencer

This block drives an external Montgomery multiplier through a complete simultaneous exponentiation, producing g0^e0 · g1^e1 mod m in the multiplier's operand store. Before a run, four operand slots are loaded elsewhere: slot 0 holds g0 in Montgomery form, slot 1 holds g1 in Montgomery form, slot 2 holds their Montgomery product, and slot 3 holds the accumulator, initialised to R mod m. The two exponents reach the block through an internal word queue. Each word carries a slice of e1 in its upper half and the matching slice of e0 in its lower half. Software pushes the slices most significant first.

A run is launched by a one-cycle start pulse while exponent mode is high. For every bit pair, most significant bit first, the block first orders a squaring of the accumulator. It then orders a multiplication of the accumulator by the slot that the pair selects, or skips that step when both bits are zero. Each operation is a one-cycle multiplier start with stable selects, and the block waits for the multiplier's ready before it moves on. When the queue is empty at the point where the next word is needed, the block raises its own ready for one cycle. On average this costs 7/4 multiplications per exponent bit.

Top module: `simexp_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, ready, mul_start, exp_full and exp_nopush are low.
- R2: exp_full is high exactly when the queue holds DEPTH words.
- R3: A push while exp_full is high is discarded, leaving the queue contents unchanged, and exp_nopush is high for the one cycle after it.
- R4: A run starts only on start high together with exp_mode high while the block is idle. A start with exp_mode low orders no operation, raises no ready and consumes no queue word.
- R5: Every bit pair begins with a squaring: mul_start with x_sel, y_sel and dest_sel all equal to 3.
- R6: After the squaring, with pair = {e1 bit, e0 bit}, pair 01 orders x_sel=3, y_sel=0; pair 10 orders x_sel=3, y_sel=1; pair 11 orders x_sel=3, y_sel=2. Each of these uses dest_sel=3. Pair 00 orders no multiplication.
- R7: Words are consumed in push order. Within a word, e1 lies in bits [WORD_W-1:WORD_W/2] and e0 in bits [WORD_W/2-1:0], and bit positions are scanned from WORD_W/2-1 down to 0.
- R8: mul_start is a one-cycle pulse. The selects hold their values until the multiplier answers, and no new mul_start is issued until mul_ready has been seen.
- R9: When a word is needed and the queue is empty, ready pulses for exactly one cycle and the block returns to idle. This includes a run started on an empty queue, which issues no operation at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exp_wdata | input | WORD_W | Exponent word: e1 slice high, e0 slice low |
| exp_push | input | 1 | Write exp_wdata into the queue |
| exp_full | output | 1 | Queue holds DEPTH words |
| exp_nopush | output | 1 | One-cycle flag: the previous push was rejected |
| start | input | 1 | Launch pulse |
| exp_mode | input | 1 | Must be high with start to launch a run |
| ready | output | 1 | One-cycle pulse: exponentiation finished |
| mul_start | output | 1 | One-cycle multiplier launch |
| mul_ready | input | 1 | Multiplier finished the current operation |
| x_sel | output | 2 | Multiplier x operand slot |
| y_sel | output | 2 | Multiplier y operand slot |
| dest_sel | output | 2 | Multiplier result slot |

## Verification
The bench builds the block with WORD_W=32 and DEPTH=4. The shallow queue makes it possible to reach the full flag, a rejected fifth push and a run that drains a completely full queue within a few thousand cycles. The 16-bit slices keep every run short enough that the bench can compare the full ordered trace of multiplier commands against a list it derives from the pushed words. The multiplier stub's latency is changed from run to run, so that waiting on mul_ready is exercised with replies that arrive both immediately and late.

// File: rtl/simexp_seq.sv
module simexp_seq #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] exp_wdata,
  input  logic              exp_push,
  output logic              exp_full,
  output logic              exp_nopush,
  input  logic              start,
  input  logic              exp_mode,
  output logic              ready,
  output logic              mul_start,
  input  logic              mul_ready,
  output logic [1:0]        x_sel,
  output logic [1:0]        y_sel,
  output logic [1:0]        dest_sel
);
  localparam int HALF = WORD_W / 2;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int BW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
  localparam logic [BW-1:0] TOP_BIT   = BW'(HALF - 1);
  localparam logic [1:0]    ACC       = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SQ_GO, S_SQ_WAIT, S_MU_GO, S_MU_WAIT, S_DONE
  } state_t;

  state_t            state;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;
  logic [WORD_W-1:0] cur;
  logic [BW-1:0]     bidx;
  logic [1:0]        pair;
  logic              do_push, do_pop, last_bit;

  assign exp_full = (count == CW'(DEPTH));
  assign do_push  = exp_push && !exp_full;
  assign do_pop   = (state == S_FETCH) && (count != '0);
  assign pair     = {cur[HALF + int'(bidx)], cur[bidx]};
  assign last_bit = (bidx == '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= exp_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      count      <= '0;
      exp_nopush <= 1'b0;
    end else begin
      exp_nopush <= exp_push && exp_full;
      if (do_push) wptr <= (wptr == LAST_SLOT) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST_SLOT) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cur   <= '0;
      bidx  <= '0;
    end else begin
      case (state)
        S_IDLE:    if (start && exp_mode) state <= S_FETCH;
        S_FETCH:
          if (count == '0) state <= S_DONE;
          else begin
            cur   <= mem[rptr];
            bidx  <= TOP_BIT;
            state <= S_SQ_GO;
          end
        S_SQ_GO:   state <= S_SQ_WAIT;
        S_SQ_WAIT:
          if (mul_ready) begin
            if (pair != 2'b00) state <= S_MU_GO;
            else if (last_bit) state <= S_FETCH;
            else begin
              bidx  <= bidx - 1'b1;
              state <= S_SQ_GO;
            end
          end
        S_MU_GO:   state <= S_MU_WAIT;
        S_MU_WAIT:
          if (mul_ready) begin
            if (last_bit) state <= S_FETCH;
            else begin
              bidx  <= bidx - 1'b1;
              state <= S_SQ_GO;
            end
          end
        S_DONE:    state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign ready     = (state == S_DONE);
  assign mul_start = (state == S_SQ_GO) || (state == S_MU_GO);

  always_comb begin
    x_sel    = 2'd0;
    y_sel    = 2'd0;
    dest_sel = 2'd0;
    if (state == S_SQ_GO || state == S_SQ_WAIT) begin
      x_sel    = ACC;
      y_sel    = ACC;
      dest_sel = ACC;
    end else if (state == S_MU_GO || state == S_MU_WAIT) begin
      x_sel    = ACC;
      y_sel    = pair - 2'd1;
      dest_sel = ACC;
    end
  end
endmodule

module simexp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       exp_push,
  input logic       exp_full,
  input logic       exp_nopush,
  input logic       ready,
  input logic       mul_start,
  input logic [1:0] x_sel,
  input logic [1:0] y_sel,
  input logic [1:0] dest_sel
);
  p_reject_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (exp_push && exp_full) |=> exp_nopush);

  p_nopush_cause_r3: assert property (@(posedge clk) disable iff (rst)
    exp_nopush |-> $past(exp_push && exp_full));

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mul_start |=> !mul_start);

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mul_start |=> $stable({x_sel, y_sel, dest_sel}));

  p_acc_target_r5: assert property (@(posedge clk) disable iff (rst)
    mul_start |-> (dest_sel == 2'd3 && x_sel == 2'd3));

  p_no_slot3_mul_r6: assert property (@(posedge clk) disable iff (rst)
    (mul_start && $past(mul_start) == 1'b0 && y_sel != 2'd3) |-> (x_sel == 2'd3));

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ready |-> !mul_start);
endmodule

bind simexp_seq simexp_seq_chk u_chk (
  .clk(clk), .rst(rst), .exp_push(exp_push), .exp_full(exp_full),
  .exp_nopush(exp_nopush), .ready(ready), .mul_start(mul_start),
  .x_sel(x_sel), .y_sel(y_sel), .dest_sel(dest_sel)
);

// File: tb/simexp_seq_bench.sv
module simexp_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 4;
  localparam int HALF   = WORD_W / 2;
  localparam int NVEC   = 4;
  localparam int MAXREC = 1024;

  localparam logic [31:0] VW [NVEC*4] = '{
    32'hA5A5_0F0F, 32'h0, 32'h0, 32'h0,
    32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 32'h0,
    32'h1234_ABCD, 32'h8000_0001, 32'h0F0F_F0F0, 32'hFFFF_0000,
    32'h0000_FFFF, 32'h5555_AAAA, 32'hC3C3_3C3C, 32'h0
  };
  localparam int VN [NVEC] = '{1, 2, 4, 3};

  logic clk = 0, rst = 1;
  logic [WORD_W-1:0] exp_wdata = '0;
  logic exp_push = 0, start = 0, exp_mode = 0, mul_ready = 0;
  logic exp_full, exp_nopush, ready, mul_start;
  logic [1:0] x_sel, y_sel, dest_sel;

  int checks = 0, fails = 0;
  int lat = 1, cnt = 0, nrec = 0, viol = 0;
  logic [5:0] rec [MAXREC];
  logic [5:0] expl [MAXREC];
  int nexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  simexp_seq #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_simexp_seq (
    .clk(clk), .rst(rst), .exp_wdata(exp_wdata), .exp_push(exp_push),
    .exp_full(exp_full), .exp_nopush(exp_nopush), .start(start),
    .exp_mode(exp_mode), .ready(ready), .mul_start(mul_start),
    .mul_ready(mul_ready), .x_sel(x_sel), .y_sel(y_sel), .dest_sel(dest_sel)
  );

  // multiplier stub: replies lat cycles after a launch
  always @(posedge clk) begin
    mul_ready <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) mul_ready <= 1'b1;
    end else if (mul_start) cnt <= lat;
  end

  always @(negedge clk) begin
    if (!rst && mul_start) begin
      if (cnt > 0 || mul_ready) viol = viol + 1;
      if (nrec < MAXREC) rec[nrec] = {x_sel, y_sel, dest_sel};
      nrec = nrec + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    exp_wdata = w;
    exp_push = 1;
    @(posedge clk); #1;
    exp_push = 0;
  endtask

  task automatic add_word(input logic [31:0] w);
    for (int b = HALF - 1; b >= 0; b--) begin
      logic [1:0] p;
      expl[nexp++] = 6'b11_11_11;
      p = {w[HALF + b], w[b]};
      if (p != 2'b00) expl[nexp++] = {2'd3, p - 2'd1, 2'd3};
    end
  endtask

  task automatic run_and_compare(input string tag);
    int base, got, n_ready;
    base = nrec;
    start = 1; exp_mode = 1;
    @(posedge clk); #1;
    start = 0; exp_mode = 0;
    n_ready = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ready) begin n_ready = 1; break; end
    end
    chk(n_ready == 1, {tag, " R9 ready"}, n_ready, 1);
    @(negedge clk);
    chk(ready == 0, {tag, " R9 ready width"}, ready, 0);
    got = nrec - base;
    chk(got == nexp, {tag, " R5 R6 op count"}, got, nexp);
    for (int i = 0; i < nexp && i < got; i++)
      chk(rec[base + i] == expl[i], {tag, " R7 op order"}, rec[base + i], expl[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ready == 0 && mul_start == 0 && exp_full == 0 && exp_nopush == 0,
        "R1 in reset", {ready, mul_start, exp_full, exp_nopush}, 0);
    rst = 0;
    @(negedge clk);
    chk(ready == 0 && mul_start == 0 && exp_full == 0 && exp_nopush == 0,
        "R1 after reset", {ready, mul_start, exp_full, exp_nopush}, 0);
    @(posedge clk); #1;

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      lat = 1 + 2 * v;
      nexp = 0;
      for (int k = 0; k < VN[v]; k++) begin
        push(VW[v*4 + k]);
        add_word(VW[v*4 + k]);
      end
      run_and_compare($sformatf("vec%0d", v));
    end

    // empty queue: immediate ready, no operation (R9)
    nexp = 0;
    run_and_compare("empty R9");

    // start without exp_mode is ignored (R4)
    lat = 2;
    push(32'h0003_0001);
    begin
      int base;
      int rdy;
      base = nrec; rdy = 0;
      start = 1; exp_mode = 0;
      @(posedge clk); #1;
      start = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (ready) rdy = 1;
      end
      chk(nrec == base && rdy == 0, "R4 no launch without mode", nrec - base + rdy, 0);
    end
    nexp = 0;
    add_word(32'h0003_0001);
    run_and_compare("R4 word kept");

    // full flag, rejected push, unchanged contents (R2, R3)
    lat = 4;
    nexp = 0;
    push(32'h8001_0002); add_word(32'h8001_0002);
    push(32'h4000_4000); add_word(32'h4000_4000);
    push(32'h0000_0007); add_word(32'h0000_0007);
    @(negedge clk);
    chk(exp_full == 0, "R2 not full at DEPTH-1", exp_full, 0);
    @(posedge clk); #1;
    push(32'hF0F0_0F0F); add_word(32'hF0F0_0F0F);
    @(negedge clk);
    chk(exp_full == 1, "R2 full at DEPTH", exp_full, 1);
    @(posedge clk); #1;
    exp_wdata = 32'hFFFF_FFFF; exp_push = 1;
    @(negedge clk);
    chk(exp_nopush == 0, "R3 nopush before edge", exp_nopush, 0);
    @(posedge clk); #1;
    exp_push = 0;
    @(negedge clk);
    chk(exp_nopush == 1, "R3 nopush pulse", exp_nopush, 1);
    @(negedge clk);
    chk(exp_nopush == 0, "R3 nopush one cycle", exp_nopush, 0);
    @(posedge clk); #1;
    run_and_compare("R3 contents");
    chk(exp_full == 0, "R2 drained", exp_full, 0);

    chk(viol == 0, "R8 launch before reply", viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule